// File: doc/BRIEF.md
# SCSI Controller Interrupt Status Unit

This block gathers the error and bus-event conditions of a SCSI protocol controller into one 8-bit interrupt status register that the CPU reads. It also drives an interrupt line that stays high while any flag is set. The flags come from several sources:

- a rising edge on the bus reset line;
- offset-counter checks at the end of a synchronous transfer;
- a legality check on the group field of a received command;
- misuse of control commands;
- selection or reselection by another device;
- loss of arbitration.

Each flag is sticky. The CPU services an interrupt by reading the register and writing the same value back. Every 1 in the written value clears that flag. A separate write strobe, for the reset register, returns the whole block to its initial state whatever data comes with it. The block tracks whether a control command is executing, and which one, so that it can detect command collisions and ignore selections the unit brought about itself. When arbitration is lost and no other device selects or reselects the unit in that cycle, the block raises a suspend output.

Top module: `scsi_irq_status`

## Requirements
- R1: `stat_rdata` is `{1'b0, flags[6:0]}`. Bit 7 always reads 0. The flag bits are: bit 6 bus reset, bit 5 offset error, bit 4 undefined group, bit 3 command error, bit 2 reselected, bit 1 selected, bit 0 lost arbitration.
- R2: A `stat_wr` cycle clears each flag whose `wdata` bit is 1 and leaves alone each flag whose `wdata` bit is 0. Without a write, a set flag stays set.
- R3: If a clear and a set event reach the same flag in the same cycle, the flag is set afterwards.
- R4: `irq` is high exactly when at least one of bits 6:0 is set.
- R5: Bit 6 sets on a 0-to-1 transition of `bus_rst`. A level that stays high does not set it again after it has been cleared.
- R6: Bit 5 sets when `xfer_end` arrives while `ofs_nz` is 1. It also sets on `ofs_ovf` or `ofs_unf` while `sync_active` is 1.
- R7: On `cmd_rx`, bit 4 sets when `cmd_byte[7:5]` is any value other than 0, 1, 2 or 5.
- R8: Bit 3 sets when `ctl_issue` carries a code outside the valid list. The default valid codes are 1, 2, 3, 4, 8 and 9. A rejected code does not start execution.
- R9: Bit 3 sets when `ctl_issue` comes while a command is busy and `ctl_done` is not high in that cycle. A valid issue starts the busy state. `ctl_done` ends it.
- R10: `sel_in` sets bit 1 unless the busy command is the selection-making code. That code is 1 by default.
- R11: `resel_in` sets bit 2 unless the busy command is the reselection-making code. That code is 2 by default.
- R12: `arb_lost` sets bit 0. When `arb_lost` comes with neither `sel_in` nor `resel_in` in that cycle, the following happen:
  - `suspend` rises;
  - any busy command ends;
  - `suspend` stays high until bit 0 is cleared.
- R13: An `init_wr` cycle, whatever the data, clears all flags, the busy state and `suspend`. A set event in that same cycle is dropped.
- R14: After `rst_n` is released, `stat_rdata` is 0 and `irq` and `suspend` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_wr | input | 1 | Write strobe to the reset register (data ignored) |
| stat_wr | input | 1 | Write strobe to the status register |
| wdata | input | 8 | Write data; a 1 clears the matching flag |
| bus_rst | input | 1 | Bus reset line level |
| sync_active | input | 1 | A synchronous transfer is in progress |
| xfer_end | input | 1 | End-of-transfer strobe |
| ofs_nz | input | 1 | Offset counter is nonzero |
| ofs_ovf | input | 1 | Offset counter overflow strobe |
| ofs_unf | input | 1 | Offset counter underflow strobe |
| cmd_rx | input | 1 | First command byte received strobe |
| cmd_byte | input | 8 | First command byte |
| ctl_issue | input | 1 | Control command issue strobe |
| ctl_code | input | CW | Control command code |
| ctl_done | input | 1 | Running control command finished |
| sel_in | input | 1 | Another device selected this unit |
| resel_in | input | 1 | Another device reselected this unit |
| arb_lost | input | 1 | Arbitration lost |
| stat_rdata | output | 8 | Interrupt status register |
| irq | output | 1 | Interrupt request |
| suspend | output | 1 | Control-command execution suspended |

## Verification
Every cycle, the assertions check the following:
- bit 7 reads 0;
- flags stay set unless a write clears them;
- a set event beats a simultaneous clear;
- an initialization write empties the register;
- a command collision raises the command-error flag;
- `suspend` never stands without the lost-arbitration flag.

Some behaviour shows only in the bench's sequences, which compare against a reference model. These are the edge-only response to a held bus reset, the group decoding of command bytes, the masking of selections caused by the unit's own commands, and the way `suspend` drops when bit 0 is cleared.

// File: rtl/scsi_irq_status.sv
module scsi_irq_status #(
  parameter int CW = 4,
  parameter int NUM_CODES = 6,
  parameter logic [NUM_CODES*CW-1:0] VALID_CODES = {4'h9, 4'h8, 4'h4, 4'h3, 4'h2, 4'h1},
  parameter logic [CW-1:0] SEL_CODE = 4'h1,
  parameter logic [CW-1:0] RESEL_CODE = 4'h2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          init_wr,
  input  logic          stat_wr,
  input  logic [7:0]    wdata,
  input  logic          bus_rst,
  input  logic          sync_active,
  input  logic          xfer_end,
  input  logic          ofs_nz,
  input  logic          ofs_ovf,
  input  logic          ofs_unf,
  input  logic          cmd_rx,
  input  logic [7:0]    cmd_byte,
  input  logic          ctl_issue,
  input  logic [CW-1:0] ctl_code,
  input  logic          ctl_done,
  input  logic          sel_in,
  input  logic          resel_in,
  input  logic          arb_lost,
  output logic [7:0]    stat_rdata,
  output logic          irq,
  output logic          suspend
);

  logic [6:0]    flags, set_ev, flags_nx;
  logic          busy, rst_q, susp_q, code_ok, grp_bad, susp_set, accept;
  logic [CW-1:0] cur;
  logic [2:0]    grp;

  always_comb begin
    code_ok = 1'b0;
    for (int i = 0; i < NUM_CODES; i++)
      if (VALID_CODES[i*CW +: CW] == ctl_code) code_ok = 1'b1;
  end

  assign grp      = cmd_byte[7:5];
  assign grp_bad  = !(grp == 3'd0 || grp == 3'd1 || grp == 3'd2 || grp == 3'd5);
  assign susp_set = arb_lost & ~sel_in & ~resel_in;
  assign accept   = ctl_issue & code_ok & (~busy | ctl_done);

  assign set_ev[6] = bus_rst & ~rst_q;
  assign set_ev[5] = (xfer_end & ofs_nz) | ((ofs_ovf | ofs_unf) & sync_active);
  assign set_ev[4] = cmd_rx & grp_bad;
  assign set_ev[3] = ctl_issue & (~code_ok | (busy & ~ctl_done));
  assign set_ev[2] = resel_in & ~(busy && cur == RESEL_CODE);
  assign set_ev[1] = sel_in & ~(busy && cur == SEL_CODE);
  assign set_ev[0] = arb_lost;

  assign flags_nx = (flags & ~(stat_wr ? wdata[6:0] : 7'd0)) | set_ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags  <= '0;
      busy   <= 1'b0;
      cur    <= '0;
      susp_q <= 1'b0;
      rst_q  <= 1'b0;
    end else if (init_wr) begin
      flags  <= '0;
      busy   <= 1'b0;
      cur    <= '0;
      susp_q <= 1'b0;
      rst_q  <= bus_rst;
    end else begin
      flags  <= flags_nx;
      rst_q  <= bus_rst;
      susp_q <= susp_set | (susp_q & flags_nx[0]);
      if (susp_set) busy <= 1'b0;
      else if (accept) begin
        busy <= 1'b1;
        cur  <= ctl_code;
      end else if (ctl_done) busy <= 1'b0;
    end
  end

  assign stat_rdata = {1'b0, flags};
  assign irq        = |flags;
  assign suspend    = susp_q;

  a_r1_msb_zero: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rdata[7] == 1'b0);

  a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_wr && !init_wr) |=> ((stat_rdata & $past(stat_rdata)) == $past(stat_rdata)));

  a_r3_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (!init_wr && stat_wr && wdata[4] && cmd_rx && cmd_byte[7:5] inside {3'd3, 3'd4, 3'd6, 3'd7})
      |=> stat_rdata[4]);

  a_r4_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !stat_wr && !init_wr) |=> irq);

  a_r9_collide: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_issue && busy && !ctl_done && !init_wr) |=> stat_rdata[3]);

  a_r12_susp_flag: assert property (@(posedge clk) disable iff (!rst_n)
    suspend |-> stat_rdata[0]);

  a_r13_init_clears: assert property (@(posedge clk) disable iff (!rst_n)
    init_wr |=> (stat_rdata == 8'd0 && !suspend && !irq));

endmodule

// File: tb/scsi_irq_status_bench.sv
`timescale 1ns/1ps
module scsi_irq_status_bench;
  logic clk = 0, rst_n = 0;
  logic init_wr = 0, stat_wr = 0, bus_rst = 0, sync_active = 0, xfer_end = 0, ofs_nz = 0;
  logic ofs_ovf = 0, ofs_unf = 0, cmd_rx = 0, ctl_issue = 0, ctl_done = 0;
  logic sel_in = 0, resel_in = 0, arb_lost = 0;
  logic [7:0] wdata = 0, cmd_byte = 0;
  logic [3:0] ctl_code = 0;
  logic [7:0] stat_rdata;
  logic irq, suspend;
  int checks = 0, fails = 0;
  bit done = 0;

  logic [6:0] m_flags = 0;
  logic m_busy = 0, m_susp = 0, m_prev = 0;
  logic [3:0] m_cur = 0;

  always #2 clk = ~clk;

  scsi_irq_status u_scsi_irq_status (.*);

  function automatic bit code_valid(input logic [3:0] c);
    return c inside {4'h1, 4'h2, 4'h3, 4'h4, 4'h8, 4'h9};
  endfunction

  function automatic logic [6:0] set_vec();
    logic [6:0] s;
    s[6] = bus_rst & ~m_prev;
    s[5] = (xfer_end & ofs_nz) | ((ofs_ovf | ofs_unf) & sync_active);
    s[4] = cmd_rx & !(cmd_byte[7:5] inside {3'd0, 3'd1, 3'd2, 3'd5});
    s[3] = ctl_issue & (!code_valid(ctl_code) | (m_busy & ~ctl_done));
    s[2] = resel_in & ~(m_busy && m_cur == 4'h2);
    s[1] = sel_in & ~(m_busy && m_cur == 4'h1);
    s[0] = arb_lost;
    return s;
  endfunction

  task automatic model_step();
    logic [6:0] nx;
    logic ss;
    if (init_wr) begin
      m_flags = 0; m_busy = 0; m_cur = 0; m_susp = 0; m_prev = bus_rst;
    end else begin
      nx = (m_flags & ~(stat_wr ? wdata[6:0] : 7'd0)) | set_vec();
      ss = arb_lost & ~sel_in & ~resel_in;
      m_susp = ss | (m_susp & nx[0]);
      if (ss) m_busy = 0;
      else if (ctl_issue && code_valid(ctl_code) && (!m_busy || ctl_done)) begin
        m_busy = 1; m_cur = ctl_code;
      end else if (ctl_done) m_busy = 0;
      m_flags = nx;
      m_prev = bus_rst;
    end
  endtask

  task automatic compare(input string tag);
    checks++;
    if (stat_rdata !== {1'b0, m_flags} || irq !== (|m_flags) || suspend !== m_susp) begin
      fails++;
      $display("FAIL %s: actual rdata=%02h irq=%0b susp=%0b expected rdata=%02h irq=%0b susp=%0b",
               tag, stat_rdata, irq, suspend, {1'b0, m_flags}, |m_flags, m_susp);
    end
  endtask

  task automatic cyc(input string tag);
    model_step();
    @(posedge clk); #1;
    compare(tag);
    @(negedge clk);
    init_wr = 0; stat_wr = 0; xfer_end = 0; ofs_ovf = 0; ofs_unf = 0; cmd_rx = 0;
    ctl_issue = 0; ctl_done = 0; sel_in = 0; resel_in = 0; arb_lost = 0; wdata = 0;
  endtask

  task automatic wr(input logic [7:0] d, input string tag);
    stat_wr = 1; wdata = d; cyc(tag);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1 compare("R14 reset state");
    @(negedge clk);
    // R7 group decode
    cmd_rx = 1; cmd_byte = 8'hA3; cyc("R7 group5 legal");
    cmd_rx = 1; cmd_byte = 8'h28; cyc("R7 group1 legal");
    cmd_rx = 1; cmd_byte = 8'h60; cyc("R7 group3 undefined");
    wr(8'h00, "R2 zero write keeps");
    wr(8'hFF, "R1 bit7 stays zero after clear");
    // R3 set wins
    cmd_rx = 1; cmd_byte = 8'hE0; stat_wr = 1; wdata = 8'h10; cyc("R3 set beats clear");
    wr(8'h10, "R2 clear bit4");
    // R5 edge detect
    bus_rst = 1; cyc("R5 edge sets");
    wr(8'h40, "R5 held level no reset");
    cyc("R5 held level stays clear");
    bus_rst = 0; cyc("R5 release");
    // R6 offset
    xfer_end = 1; ofs_nz = 0; cyc("R6 zero at end ok");
    xfer_end = 1; ofs_nz = 1; cyc("R6 nonzero at end");
    ofs_nz = 0; wr(8'h20, "R6 clear");
    ofs_ovf = 1; sync_active = 0; cyc("R6 ovf outside sync ignored");
    ofs_unf = 1; sync_active = 1; cyc("R6 underflow");
    sync_active = 0; wr(8'h20, "R6 clear");
    // R8 / R9
    ctl_issue = 1; ctl_code = 4'h5; cyc("R8 unknown code");
    wr(8'h08, "R8 clear");
    ctl_issue = 1; ctl_code = 4'h3; cyc("R9 accept");
    ctl_issue = 1; ctl_code = 4'h4; cyc("R9 collision");
    wr(8'h08, "R9 clear");
    ctl_issue = 1; ctl_code = 4'h4; ctl_done = 1; cyc("R9 issue with done ok");
    ctl_done = 1; cyc("R9 done");
    ctl_issue = 1; ctl_code = 4'h8; cyc("R9 idle issue ok");
    ctl_done = 1; cyc("R9 done");
    // R10 / R11
    ctl_issue = 1; ctl_code = 4'h1; cyc("R10 start select cmd");
    sel_in = 1; cyc("R10 own select masked");
    resel_in = 1; cyc("R11 resel during select cmd");
    ctl_done = 1; cyc("R10 done");
    sel_in = 1; cyc("R10 foreign select");
    ctl_issue = 1; ctl_code = 4'h2; cyc("R11 start resel cmd");
    resel_in = 1; cyc("R11 own resel masked");
    ctl_done = 1; cyc("R11 done");
    wr(8'h06, "R2 clear sel flags");
    // R12
    arb_lost = 1; sel_in = 1; cyc("R12 lost but selected no suspend");
    wr(8'h03, "R12 clear");
    ctl_issue = 1; ctl_code = 4'h3; cyc("R12 busy");
    arb_lost = 1; cyc("R12 suspend");
    ctl_issue = 1; ctl_code = 4'h4; cyc("R12 busy ended by suspend");
    wr(8'h01, "R12 suspend drops with bit0");
    ctl_done = 1; cyc("R12 done");
    // R13
    bus_rst = 1; cmd_rx = 1; cmd_byte = 8'hC0; cyc("R13 preload");
    init_wr = 1; arb_lost = 1; wdata = 8'h5A; cyc("R13 init clears");
    cyc("R13 held bus reset no edge");
    bus_rst = 0;
    // random
    for (int n = 0; n < 4000; n++) begin
      stat_wr     = ($urandom % 3) == 0;
      wdata       = $urandom;
      init_wr     = ($urandom % 97) == 0;
      if (($urandom % 11) == 0) bus_rst = ~bus_rst;
      sync_active = ($urandom % 2);
      xfer_end    = ($urandom % 9) == 0;
      ofs_nz      = ($urandom % 2);
      ofs_ovf     = ($urandom % 15) == 0;
      ofs_unf     = ($urandom % 15) == 0;
      cmd_rx      = ($urandom % 5) == 0;
      cmd_byte    = $urandom;
      ctl_issue   = ($urandom % 4) == 0;
      ctl_code    = $urandom;
      ctl_done    = ($urandom % 6) == 0;
      sel_in      = ($urandom % 8) == 0;
      resel_in    = ($urandom % 8) == 0;
      arb_lost    = ($urandom % 12) == 0;
      cyc("R2 random mix");
    end
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule